// File: doc/BRIEF.md
# Microframe SOF Lock Tracker

This block sits on the device side of a USB receive path. It watches decoded start-of-frame packets, keeps the current frame number and raises a sticky frame-update interrupt each time it accepts a new number. A packet decoder upstream supplies a one-cycle strobe per received SOF. The strobe comes with the 11-bit frame number and an error flag for that packet.

At full speed every error-free SOF is accepted. At high speed the block first has to qualify the incoming microframe stream. It enters a locked state only after consecutive error-free SOFs carry different frame numbers. Until then it keeps the frame number and the interrupt unchanged. An enable input starts and stops this lock monitoring. A speed-mode input selects full or high speed. Software clears the interrupt with a one-cycle clear strobe.

Top module: `sof_lock_tracker`

## Requirements
- R1: After synchronous reset, `frame_num` is 0, `locked` is 0 and `frame_irq` is 0.
- R2: With `hs_mode`=0, an SOF strobe with `sof_err`=0 loads `sof_frame` into `frame_num` and sets `frame_irq` on the next clock edge, whatever the value of `mon_en`. An SOF with `sof_err`=1 changes neither output.
- R3: While `hs_mode`=0, `locked` is 0 one cycle later.
- R4: With `hs_mode`=1 and `locked`=0, an SOF that does not complete lock leaves `frame_num` and `frame_irq` unchanged.
- R5: With `hs_mode`=1 and `mon_en`=1, a second error-free SOF whose number differs from the error-free SOF just before it sets `locked`, loads its number into `frame_num` and sets `frame_irq`, all on the next edge. Idle cycles between the two SOFs do not matter.
- R6: While unlocked at high speed, an SOF with `sof_err`=1 discards the qualification. An error-free SOF whose number equals the previous one restarts the qualification with itself as the first SOF.
- R7: While locked, an error-free SOF loads `frame_num` and sets `frame_irq` only if its number differs from `frame_num`. SOFs with an equal number, or with `sof_err`=1, change nothing, and `locked` stays 1.
- R8: When `mon_en` is 0 at high speed, `locked` is 0 on the next edge, the qualification is discarded and no SOF is accepted.
- R9: When `hs_mode` differs from its value in the previous cycle, the lock and the qualification are dropped, and an SOF in that cycle is ignored. Just after reset the previous value counts as 0.
- R10: `frame_irq` stays 1 until a cycle with `irq_clr`=1. A clear and a new accepted SOF in the same cycle leave `frame_irq` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Enables high-speed lock monitoring |
| hs_mode | input | 1 | 1 = high speed, 0 = full speed |
| sof_valid | input | 1 | One-cycle strobe for a received SOF |
| sof_frame | input | 11 | Frame number carried by the SOF |
| sof_err | input | 1 | The SOF was received with an error |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt |
| frame_num | output | 11 | Current accepted frame number |
| locked | output | 1 | High-speed microframe lock achieved |
| frame_irq | output | 1 | Sticky frame-update interrupt status |

## Verification
A stale or wrongly advanced qualification counter shows up at the ports only at the next high-speed SOF. Lock then arrives one SOF early or late, and `locked`, `frame_num` and `frame_irq` all diverge on the same edge. A stored reference number that was not refreshed on an equal SOF shows up in the same way, at the following SOF. The bench therefore compares all three outputs against a behavioural model on every cycle. Its sequences place error SOFs, repeated numbers, enable drops and mode flips immediately before the SOF that would lock. A lock bit left set after a mode or enable change appears within one cycle.

// File: rtl/sof_pkg.sv
package sof_pkg;

    typedef enum logic {
        SPD_FULL = 1'b0,
        SPD_HIGH = 1'b1
    } speed_e;

    typedef struct packed {
        logic good;
        logic bad;
    } sof_kind_t;

    function automatic sof_kind_t classify_sof(input logic valid, input logic err);
        sof_kind_t k;
        k.good = valid & ~err;
        k.bad  = valid & err;
        return k;
    endfunction

endpackage

// File: rtl/sof_lock_qual.sv
module sof_lock_qual
    import sof_pkg::*;
#(
    parameter int FRAME_W  = 11,
    parameter int LOCK_RUN = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  sof_kind_t          kind,
    input  logic [FRAME_W-1:0] frame,
    output logic               locked,
    output logic               lock_now
);
    localparam int CNT_W = $clog2(LOCK_RUN + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(LOCK_RUN - 1);

    logic [CNT_W-1:0]   run_cnt;
    logic [FRAME_W-1:0] ref_frame;
    logic               differs;

    assign differs  = (frame != ref_frame);
    assign lock_now = ~clr & ~locked & kind.good & (run_cnt != '0) & differs
                    & (run_cnt == LAST_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt   <= '0;
            ref_frame <= '0;
            locked    <= 1'b0;
        end else if (clr) begin
            run_cnt <= '0;
            locked  <= 1'b0;
        end else if (!locked) begin
            if (kind.bad) begin
                run_cnt <= '0;
            end else if (kind.good) begin
                ref_frame <= frame;
                if (run_cnt == '0 || !differs) begin
                    run_cnt <= CNT_W'(1);
                end else if (lock_now) begin
                    run_cnt <= '0;
                    locked  <= 1'b1;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end
    end

    AST_LOCK_NEEDS_GOOD: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(kind.good)); // R5
    AST_BAD_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
        (!locked && kind.bad) |=> !locked); // R6
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        clr |=> !locked); // R8

endmodule

// File: rtl/sof_frame_reg.sv
module sof_frame_reg #(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               irq_clr,
    output logic [FRAME_W-1:0] frame_q,
    output logic               irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            irq     <= 1'b0;
        end else begin
            if (load) frame_q <= frame_in;
            if (load)         irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
        end
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq); // R10
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !load) |=> !irq); // R10
    AST_LOAD_SETS: assert property (@(posedge clk) disable iff (rst)
        load |=> (irq && frame_q == $past(frame_in))); // R2

endmodule

// File: rtl/sof_lock_tracker.sv
module sof_lock_tracker
    import sof_pkg::*;
#(
    parameter int FRAME_W  = 11,
    parameter int LOCK_RUN = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mon_en,
    input  logic               hs_mode,
    input  logic               sof_valid,
    input  logic [FRAME_W-1:0] sof_frame,
    input  logic               sof_err,
    input  logic               irq_clr,
    output logic [FRAME_W-1:0] frame_num,
    output logic               locked,
    output logic               frame_irq
);
    speed_e    spd, spd_prev;
    sof_kind_t kind;
    logic      mode_chg, lock_clr, lock_now, fs_load, hs_load, load;

    assign spd      = speed_e'(hs_mode);
    assign kind     = classify_sof(sof_valid, sof_err);
    assign mode_chg = (spd != spd_prev);
    assign lock_clr = (spd == SPD_FULL) | ~mon_en | mode_chg;

    always_ff @(posedge clk) begin
        if (rst) spd_prev <= SPD_FULL;
        else     spd_prev <= spd;
    end

    sof_lock_qual #(.FRAME_W(FRAME_W), .LOCK_RUN(LOCK_RUN)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .clr      (lock_clr),
        .kind     (kind),
        .frame    (sof_frame),
        .locked   (locked),
        .lock_now (lock_now)
    );

    assign fs_load = (spd == SPD_FULL) & ~mode_chg & kind.good;
    assign hs_load = (spd == SPD_HIGH) & ~lock_clr
                   & ((locked & kind.good & (sof_frame != frame_num)) | lock_now);
    assign load    = fs_load | hs_load;

    sof_frame_reg #(.FRAME_W(FRAME_W)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .frame_in (sof_frame),
        .irq_clr  (irq_clr),
        .frame_q  (frame_num),
        .irq      (frame_irq)
    );

    AST_FS_NEVER_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !hs_mode |=> !locked); // R3
    AST_HS_UNLOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hs_mode && !locked && !lock_now) |=> $stable(frame_num)); // R4
    AST_LOCKED_SAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hs_mode && mon_en && !mode_chg && locked && sof_valid && sof_frame == frame_num)
        |=> ($stable(frame_num) && locked)); // R7
    AST_MODE_FLIP_DROP: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> !locked); // R9

endmodule

// File: tb/sim_sof_lock_tracker.sv
module sim_sof_lock_tracker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mon_en = 1'b0, hs_mode = 1'b0, sof_valid = 1'b0, sof_err = 1'b0, irq_clr = 1'b0;
    logic [10:0] sof_frame = '0;
    logic [10:0] frame_num;
    logic        locked, frame_irq;

    int    checks = 0, failures = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    sof_lock_tracker u0 (
        .clk(clk), .rst(rst), .mon_en(mon_en), .hs_mode(hs_mode),
        .sof_valid(sof_valid), .sof_frame(sof_frame), .sof_err(sof_err),
        .irq_clr(irq_clr), .frame_num(frame_num), .locked(locked), .frame_irq(frame_irq)
    );

    // behavioural reference model
    int m_frame = 0, m_last = 0, m_cnt = 0;
    bit m_locked = 0, m_irq = 0, m_prevhs = 0;

    always @(posedge clk) begin
        bit chg, ok, bad, ld;
        if (rst) begin
            m_frame = 0; m_last = 0; m_cnt = 0;
            m_locked = 0; m_irq = 0; m_prevhs = 0;
        end else begin
            chg = (hs_mode != m_prevhs);
            m_prevhs = hs_mode;
            ok  = sof_valid && !sof_err;
            bad = sof_valid && sof_err;
            ld  = 0;
            if (!hs_mode) begin
                m_locked = 0; m_cnt = 0;
                if (!chg && ok) ld = 1;
            end else if (!mon_en || chg) begin
                m_locked = 0; m_cnt = 0;
            end else if (!m_locked) begin
                if (bad) m_cnt = 0;
                else if (ok) begin
                    if (m_cnt == 0 || int'(sof_frame) == m_last) m_cnt = 1;
                    else begin m_locked = 1; m_cnt = 0; ld = 1; end
                    m_last = int'(sof_frame);
                end
            end else if (ok && int'(sof_frame) != m_frame) begin
                ld = 1;
            end
            if (ld) begin m_frame = int'(sof_frame); m_irq = 1; end
            else if (irq_clr) m_irq = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (int'(frame_num) != m_frame || locked != m_locked || frame_irq != m_irq) begin
                failures++;
                $display("FAIL %s: frame=%0d locked=%0b irq=%0b expected frame=%0d locked=%0b irq=%0b",
                         cur_req, frame_num, locked, frame_irq, m_frame, m_locked, m_irq);
            end
        end
    end

    task automatic cyc(input bit v, input int f, input bit e, input bit c);
        @(negedge clk);
        sof_valid = v; sof_frame = 11'(f); sof_err = e; irq_clr = c;
    endtask

    task automatic sof(input int f, input bit e);
        cyc(1, f, e, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
    endtask

    task automatic direct(input string req, input int f, input bit l, input bit q);
        @(negedge clk);
        checks++;
        if (int'(frame_num) != f || locked != l || frame_irq != q) begin
            failures++;
            $display("FAIL %s: frame=%0d locked=%0b irq=%0b expected frame=%0d locked=%0b irq=%0b",
                     req, frame_num, locked, frame_irq, f, l, q);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        direct("R1", 0, 0, 0);

        cur_req = "R2"; // full speed: every good SOF loads
        sof(5, 0);
        direct("R2", 5, 0, 1);
        sof(9, 1);
        direct("R2", 5, 0, 1);
        cyc(0, 0, 0, 1);
        sof(5, 0);
        direct("R2", 5, 0, 1);
        cur_req = "R3";
        mon_en = 1'b1;
        sof(7, 0); sof(8, 0);
        direct("R3", 8, 0, 1);
        cyc(0, 0, 0, 1);

        cur_req = "R9"; // flip to high speed with an SOF in the same cycle
        @(negedge clk); hs_mode = 1'b1; sof_valid = 1'b1; sof_frame = 11'd100;
        cyc(0, 0, 0, 0);
        sof(101, 0);
        direct("R9", 8, 0, 0);

        cur_req = "R6"; // 101 qualified once; error discards
        sof(102, 1);
        sof(103, 0);
        sof(103, 0);
        direct("R6", 8, 0, 0);
        cur_req = "R5";
        sof(104, 0);
        direct("R5", 104, 1, 1);

        cur_req = "R7";
        cyc(0, 0, 0, 1);
        sof(104, 0); sof(200, 1);
        direct("R7", 104, 1, 0);
        sof(105, 0);
        direct("R7", 105, 1, 1);

        cur_req = "R10";
        cyc(1, 106, 0, 1);
        cyc(0, 0, 0, 0);
        direct("R10", 106, 1, 1);
        repeat (3) cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 0);
        direct("R10", 106, 1, 0);

        cur_req = "R8";
        mon_en = 1'b0;
        sof(110, 0); sof(111, 0);
        direct("R8", 106, 0, 0);
        mon_en = 1'b1;
        cur_req = "R4";
        sof(112, 0);
        direct("R4", 106, 0, 0);
        sof(113, 0);
        direct("R5", 113, 1, 1);

        cur_req = "R9";
        @(negedge clk); hs_mode = 1'b0; sof_valid = 1'b1; sof_frame = 11'd300;
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 0);
        direct("R9", 113, 0, 0);
        hs_mode = 1'b1;
        cyc(0, 0, 0, 0);
        sof(114, 0);
        direct("R4", 113, 0, 0);
        cur_req = "R6";
        sof(114, 0); sof(115, 0);
        direct("R6", 115, 1, 1);

        repeat (3) cyc(0, 0, 0, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule